// File: doc/BRIEF.md
# Planar Graphics Write/Read Datapath

This block sits between a byte-wide CPU port and four 8-bit memory planes that share one address. When the CPU reads a plane location, all four plane bytes are captured in a 32-bit latch and the CPU receives either one selected plane byte or a colour-compare result. When the CPU writes, the block forms four new plane bytes. Each byte is built from the CPU byte, a per-plane fill colour and the latched bytes. The path runs through a byte rotator, a logic unit and a per-bit mask, and the write mode sets how these are combined. A 4-bit plane enable then decides which planes actually store the result.

The configuration lives in a small register file. Software writes a register number to an index port and then reads or writes the value through a data port. The plane arrays sit outside this block. Plane read data arrives on an input bus, and write data and per-plane write enables leave on output buses in the same cycle as the write strobe.

Top module: `gfxPlanarPath`

## Requirements
- R1: After reset the index is 0, register 7 (bit mask) reads 0xFF, register 8 (plane enable) reads 0x0F and every other register reads 0.
- R2: A write to the index port stores the low 4 bits of the byte, and reading the index port returns them zero-extended. A data-port write updates the register the index selects. Data reads return that register with its unused bits as 0. Indices 9 to 15 read as 0 and ignore writes. Register map: 0 fill colour [3:0], 1 fill enable [3:0], 2 compare colour [3:0], 3 rotate/op (count [2:0], op [4:3]), 4 read plane [1:0], 5 mode (write mode [1:0], read mode [3]), 6 compare care [3:0], 7 bit mask [7:0], 8 plane enable [3:0].
- R3: Every plane read loads the 32-bit latch with all four plane bytes, plane p in bits 8p+7:8p. The byte returned to the CPU has no effect on later writes.
- R4: In read mode 0 the CPU receives the byte of the plane named by register 4.
- R5: In read mode 1, bit b of the CPU byte is 1 when, for every plane whose compare care bit is 1, bit b of that plane equals that plane's compare colour bit.
- R6: The rotator rotates right: bit b of its result is CPU bit (b+count) mod 8. The op field selects 0 pass, 1 AND latch, 2 OR latch, 3 XOR latch.
- R7: In write mode 0, a plane with its fill enable bit set uses all copies of its fill colour bit as the logic unit input. Any other plane uses the rotated CPU byte.
- R8: In write modes 0, 2 and 3, every bit position whose effective mask bit is 0 receives the latched bit. Every other position receives the logic unit output.
- R9: In write mode 1 every plane receives its latched byte unchanged.
- R10: In write mode 2, CPU bit p is replicated to 8 bits as the logic unit input of plane p, and register 7 is the mask.
- R11: In write mode 3 the logic unit input is the fill colour bit replicated. The effective mask is the rotated CPU byte ANDed with register 7.
- R12: Plane write enables equal register 8 while the write strobe is high and are 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| idxWr | input | 1 | Write strobe for the index port |
| datWr | input | 1 | Write strobe for the data port |
| regWdata | input | 8 | Byte written to the index or data port |
| idxRdata | output | 8 | Current index, zero-extended |
| datRdata | output | 8 | Contents of the indexed register |
| memRd | input | 1 | CPU read of a plane location |
| memWr | input | 1 | CPU write of a plane location |
| cpuWdata | input | 8 | CPU write byte |
| cpuRdata | output | 8 | CPU read byte |
| planeRdData | input | 32 | Four plane bytes at the addressed location |
| planeWrData | output | 32 | Four plane bytes to store |
| planeWrEn | output | 4 | Per-plane write enable |

## Verification
The bench uses the default geometry of four planes of eight bits. That is the only geometry at which the plane-byte packing, the 3-bit rotate count and the 4-bit colour fields fit together, so the full register map and every rotate amount can be reached. Random register settings cover all four write modes, both read modes and all four logic operations over random latch and CPU bytes. Directed cases cover field masking and dead indices, all-ones and all-zeros masks, and copying through write mode 1 after a read.

// File: rtl/gfxPlanarPkg.sv
package gfxPlanarPkg;
  localparam int NPLANE = 4;
  localparam int BYTE_W = 8;
  localparam int IDX_W  = 4;
  localparam int ROT_W  = $clog2(BYTE_W);
  localparam int MAP_W  = $clog2(NPLANE);
  localparam int BUS_W  = NPLANE * BYTE_W;

  typedef enum logic [1:0] {OP_PASS = 2'd0, OP_AND = 2'd1, OP_OR = 2'd2, OP_XOR = 2'd3} aluOpE;

  typedef struct packed {
    logic [NPLANE-1:0] fillColor;
    logic [NPLANE-1:0] fillEnable;
    logic [NPLANE-1:0] cmpColor;
    logic [NPLANE-1:0] cmpCare;
    logic [NPLANE-1:0] planeEnable;
    logic [ROT_W-1:0]  rotCount;
    aluOpE             aluOp;
    logic [MAP_W-1:0]  readPlane;
    logic [1:0]        wrMode;
    logic              rdMode;
    logic [BYTE_W-1:0] bitMask;
  } cfgT;

  typedef struct packed {
    logic loadLatch;
    logic doWrite;
  } strobeT;
endpackage

// File: rtl/gfxPlanarCtrl.sv
module gfxPlanarCtrl
  import gfxPlanarPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              idxWr,
  input  logic              datWr,
  input  logic [BYTE_W-1:0] regWdata,
  input  logic              memRd,
  input  logic              memWr,
  output logic [BYTE_W-1:0] idxRdata,
  output logic [BYTE_W-1:0] datRdata,
  output cfgT               cfg,
  output strobeT            strobe
);
  logic [IDX_W-1:0] idxQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      idxQ            <= '0;
      cfg             <= '0;
      cfg.bitMask     <= '1;
      cfg.planeEnable <= '1;
    end else begin
      if (idxWr) idxQ <= regWdata[IDX_W-1:0];
      if (datWr) begin
        case (idxQ)
          4'd0: cfg.fillColor   <= regWdata[NPLANE-1:0];
          4'd1: cfg.fillEnable  <= regWdata[NPLANE-1:0];
          4'd2: cfg.cmpColor    <= regWdata[NPLANE-1:0];
          4'd3: begin
            cfg.rotCount <= regWdata[ROT_W-1:0];
            cfg.aluOp    <= aluOpE'(regWdata[ROT_W+1:ROT_W]);
          end
          4'd4: cfg.readPlane   <= regWdata[MAP_W-1:0];
          4'd5: begin
            cfg.wrMode <= regWdata[1:0];
            cfg.rdMode <= regWdata[3];
          end
          4'd6: cfg.cmpCare     <= regWdata[NPLANE-1:0];
          4'd7: cfg.bitMask     <= regWdata;
          4'd8: cfg.planeEnable <= regWdata[NPLANE-1:0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    datRdata = '0;
    case (idxQ)
      4'd0: datRdata[NPLANE-1:0] = cfg.fillColor;
      4'd1: datRdata[NPLANE-1:0] = cfg.fillEnable;
      4'd2: datRdata[NPLANE-1:0] = cfg.cmpColor;
      4'd3: datRdata[ROT_W+1:0]  = {cfg.aluOp, cfg.rotCount};
      4'd4: datRdata[MAP_W-1:0]  = cfg.readPlane;
      4'd5: datRdata[3:0]        = {cfg.rdMode, 1'b0, cfg.wrMode};
      4'd6: datRdata[NPLANE-1:0] = cfg.cmpCare;
      4'd7: datRdata             = cfg.bitMask;
      4'd8: datRdata[NPLANE-1:0] = cfg.planeEnable;
      default: datRdata = '0;
    endcase
  end

  assign idxRdata         = {{(BYTE_W-IDX_W){1'b0}}, idxQ};
  assign strobe.loadLatch = memRd;
  assign strobe.doWrite   = memWr;
endmodule

// File: rtl/gfxPlanarDatapath.sv
module gfxPlanarDatapath
  import gfxPlanarPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobeT            strobe,
  input  cfgT               cfg,
  input  logic [BYTE_W-1:0] cpuWdata,
  input  logic [BUS_W-1:0]  planeRdData,
  output logic [BYTE_W-1:0] cpuRdata,
  output logic [BUS_W-1:0]  planeWrData,
  output logic [NPLANE-1:0] planeWrEn
);
  logic [BUS_W-1:0]    latchQ;
  logic [2*BYTE_W-1:0] rotWide;
  logic [BYTE_W-1:0]   rotByte;
  logic [BYTE_W-1:0]   matchVec [NPLANE];

  always_ff @(posedge clk) begin
    if (!rstN)                 latchQ <= '0;
    else if (strobe.loadLatch) latchQ <= planeRdData;
  end

  assign rotWide = {cpuWdata, cpuWdata} >> cfg.rotCount;
  assign rotByte = rotWide[BYTE_W-1:0];

  for (genvar p = 0; p < NPLANE; p++) begin : gPlane
    logic [BYTE_W-1:0] latchByte, fillByte, srcByte, aluByte, maskByte;
    assign latchByte = latchQ[p*BYTE_W +: BYTE_W];
    assign fillByte  = {BYTE_W{cfg.fillColor[p]}};

    always_comb begin
      case (cfg.wrMode)
        2'd0:    srcByte = cfg.fillEnable[p] ? fillByte : rotByte;
        2'd2:    srcByte = {BYTE_W{cpuWdata[p]}};
        2'd3:    srcByte = fillByte;
        default: srcByte = rotByte;
      endcase
      case (cfg.aluOp)
        OP_AND:  aluByte = srcByte & latchByte;
        OP_OR:   aluByte = srcByte | latchByte;
        OP_XOR:  aluByte = srcByte ^ latchByte;
        default: aluByte = srcByte;
      endcase
      maskByte = (cfg.wrMode == 2'd3) ? (rotByte & cfg.bitMask) : cfg.bitMask;
    end

    assign planeWrData[p*BYTE_W +: BYTE_W] = (cfg.wrMode == 2'd1) ? latchByte :
                                             ((aluByte & maskByte) | (latchByte & ~maskByte));
    assign matchVec[p] = ~(planeRdData[p*BYTE_W +: BYTE_W] ^ {BYTE_W{cfg.cmpColor[p]}})
                         | {BYTE_W{~cfg.cmpCare[p]}};
  end

  always_comb begin
    logic [BYTE_W-1:0] allMatch;
    allMatch = '1;
    for (int p = 0; p < NPLANE; p++) allMatch &= matchVec[p];
    cpuRdata = cfg.rdMode ? allMatch : planeRdData[cfg.readPlane*BYTE_W +: BYTE_W];
  end

  assign planeWrEn = strobe.doWrite ? cfg.planeEnable : '0;
endmodule

// File: rtl/gfxPlanarPath.sv
module gfxPlanarPath
  import gfxPlanarPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        idxWr,
  input  logic        datWr,
  input  logic [7:0]  regWdata,
  output logic [7:0]  idxRdata,
  output logic [7:0]  datRdata,
  input  logic        memRd,
  input  logic        memWr,
  input  logic [7:0]  cpuWdata,
  output logic [7:0]  cpuRdata,
  input  logic [31:0] planeRdData,
  output logic [31:0] planeWrData,
  output logic [3:0]  planeWrEn
);
  cfgT    cfg;
  strobeT strobe;

  gfxPlanarCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .idxWr(idxWr), .datWr(datWr), .regWdata(regWdata),
    .memRd(memRd), .memWr(memWr), .idxRdata(idxRdata), .datRdata(datRdata),
    .cfg(cfg), .strobe(strobe)
  );

  gfxPlanarDatapath u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cfg(cfg), .cpuWdata(cpuWdata),
    .planeRdData(planeRdData), .cpuRdata(cpuRdata), .planeWrData(planeWrData),
    .planeWrEn(planeWrEn)
  );
endmodule

// File: rtl/gfxPlanarPath_chk.sv
module gfxPlanarPath_chk
  import gfxPlanarPkg::*;
(
  input logic        clk,
  input logic        rstN,
  input logic        idxWr,
  input logic [7:0]  regWdata,
  input logic [7:0]  idxRdata,
  input logic        memRd,
  input logic        memWr,
  input logic [31:0] planeRdData,
  input logic [31:0] planeWrData,
  input logic [3:0]  planeWrEn,
  input cfgT         cfg
);
  logic [31:0] shadowLatch;
  logic [31:0] keepMask;

  always_ff @(posedge clk) begin
    if (!rstN)      shadowLatch <= '0;
    else if (memRd) shadowLatch <= planeRdData;
  end

  assign keepMask = ~{NPLANE{cfg.bitMask}};

  a_r2_index_readback: assert property (@(posedge clk) disable iff (!rstN)
    idxWr |=> idxRdata == {4'b0, $past(regWdata[3:0])});

  a_r9_copy_latch: assert property (@(posedge clk) disable iff (!rstN)
    (memWr && cfg.wrMode == 2'd1) |-> planeWrData == shadowLatch);

  a_r8_mask_keeps_latch: assert property (@(posedge clk) disable iff (!rstN)
    (memWr && cfg.wrMode != 2'd1) |-> (planeWrData & keepMask) == (shadowLatch & keepMask));

  a_r7_fill_all: assert property (@(posedge clk) disable iff (!rstN)
    (memWr && cfg.wrMode == 2'd0 && cfg.fillEnable == 4'hF && cfg.aluOp == OP_PASS && cfg.bitMask == 8'hFF)
    |-> planeWrData == {{8{cfg.fillColor[3]}}, {8{cfg.fillColor[2]}}, {8{cfg.fillColor[1]}}, {8{cfg.fillColor[0]}}});

  a_r12_idle_no_enable: assert property (@(posedge clk) disable iff (!rstN)
    !memWr |-> planeWrEn == 4'h0);

  a_r12_write_enable: assert property (@(posedge clk) disable iff (!rstN)
    memWr |-> planeWrEn == cfg.planeEnable);
endmodule

bind gfxPlanarPath gfxPlanarPath_chk u_chk (
  .clk(clk), .rstN(rstN), .idxWr(idxWr), .regWdata(regWdata), .idxRdata(idxRdata),
  .memRd(memRd), .memWr(memWr), .planeRdData(planeRdData), .planeWrData(planeWrData),
  .planeWrEn(planeWrEn), .cfg(cfg)
);

// File: tb/tb_gfxPlanarPath.sv
module tb_gfxPlanarPath;
  logic        clk = 0;
  logic        rstN = 0;
  logic        idxWr = 0, datWr = 0, memRd = 0, memWr = 0;
  logic [7:0]  regWdata = 0, cpuWdata = 0;
  logic [31:0] planeRdData = 0;
  logic [7:0]  idxRdata, datRdata, cpuRdata;
  logic [31:0] planeWrData;
  logic [3:0]  planeWrEn;

  int nChecks = 0, nFails = 0;
  bit finished = 0;

  logic [7:0]  mReg [9];
  logic [31:0] mLatch;

  always #5 clk = ~clk;

  gfxPlanarPath dut (.*);

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  function automatic logic [7:0] fieldMask(int idx);
    case (idx)
      0, 1, 2, 6, 8: return 8'h0F;
      3: return 8'h1F;
      4: return 8'h03;
      5: return 8'h0B;
      7: return 8'hFF;
      default: return 8'h00;
    endcase
  endfunction

  task automatic setIdx(logic [7:0] v);
    @(negedge clk); idxWr = 1; regWdata = v;
    @(negedge clk); idxWr = 0;
  endtask

  task automatic setReg(int idx, logic [7:0] v);
    setIdx(8'(idx));
    datWr = 1; regWdata = v;
    @(negedge clk); datWr = 0;
    if (idx < 9) mReg[idx] = v & fieldMask(idx);
  endtask

  function automatic logic [7:0] expRead(logic [31:0] pl);
    logic [7:0] r;
    if (mReg[5][3]) begin
      for (int b = 0; b < 8; b++) begin
        r[b] = 1'b1;
        for (int p = 0; p < 4; p++)
          if (mReg[6][p] && (pl[p*8+b] != mReg[2][p])) r[b] = 1'b0;
      end
    end else r = pl[mReg[4][1:0]*8 +: 8];
    return r;
  endfunction

  function automatic logic [31:0] expWrite(logic [7:0] c);
    logic [31:0] w;
    int cnt = int'(mReg[3][2:0]);
    int wm = int'(mReg[5][1:0]);
    for (int p = 0; p < 4; p++)
      for (int b = 0; b < 8; b++) begin
        logic rb, l, s, a, m;
        rb = c[(b + cnt) % 8];
        l  = mLatch[p*8+b];
        case (wm)
          0: s = mReg[1][p] ? mReg[0][p] : rb;
          2: s = c[p];
          3: s = mReg[0][p];
          default: s = rb;
        endcase
        case (mReg[3][4:3])
          2'd1: a = s & l;
          2'd2: a = s | l;
          2'd3: a = s ^ l;
          default: a = s;
        endcase
        m = (wm == 3) ? (rb & mReg[7][b]) : mReg[7][b];
        w[p*8+b] = (wm == 1) ? l : (m ? a : l);
      end
    return w;
  endfunction

  task automatic doRead(string tag, logic [31:0] pl);
    @(negedge clk); memRd = 1; planeRdData = pl;
    #1 check(tag, {24'h0, cpuRdata}, {24'h0, expRead(pl)});
    @(negedge clk); memRd = 0; mLatch = pl;
  endtask

  task automatic doWrite(string tag, logic [7:0] c);
    @(negedge clk); memWr = 1; cpuWdata = c;
    #1 check(tag, planeWrData, expWrite(c));
    check("R12 enable during write", {28'h0, planeWrEn}, {28'h0, mReg[8][3:0]});
    @(negedge clk); memWr = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nFails++; nChecks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1357));
    for (int i = 0; i < 9; i++) mReg[i] = 0;
    mReg[7] = 8'hFF; mReg[8] = 8'h0F; mLatch = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);

    // R1 reset state
    check("R1 index after reset", {24'h0, idxRdata}, 32'h0);
    for (int i = 0; i < 9; i++) begin
      setIdx(8'(i));
      #1 check($sformatf("R1 reg %0d reset", i), {24'h0, datRdata}, {24'h0, mReg[i]});
    end

    // R2 index readback and field masking
    setIdx(8'hA7);
    #1 check("R2 index readback", {24'h0, idxRdata}, 32'h07);
    setReg(0, 8'hFF);
    setIdx(8'h00);
    #1 check("R2 fill colour field mask", {24'h0, datRdata}, 32'h0F);
    setReg(5, 8'hFF);
    setIdx(8'h05);
    #1 check("R2 mode field mask", {24'h0, datRdata}, 32'h0B);
    setReg(12, 8'h5A);
    setIdx(8'h0C);
    #1 check("R2 dead index reads zero", {24'h0, datRdata}, 32'h0);
    for (int i = 0; i < 9; i++) begin
      setIdx(8'(i));
      #1 check($sformatf("R2 dead write left reg %0d", i), {24'h0, datRdata}, {24'h0, mReg[i]});
    end

    // R3/R9 copy: latch then mode-1 write; a later read return must not matter
    setReg(5, 8'h01); setReg(8, 8'h0F);
    doRead("R3 read for copy", 32'hDEADBEEF);
    doWrite("R9 copy latch", 8'h00);
    setReg(5, 8'h09);
    doRead("R5 read changes latch", 32'h12345678);
    setReg(5, 8'h01);
    doWrite("R3 latch holds new plane bytes", 8'hFF);

    // R4 read plane select
    setReg(5, 8'h00);
    for (int p = 0; p < 4; p++) begin
      setReg(4, 8'(p));
      doRead($sformatf("R4 read plane %0d", p), 32'hA1B2C3D4);
    end

    // R5 compare with no care bits -> all ones
    setReg(5, 8'h08); setReg(6, 8'h00);
    doRead("R5 no care bits", 32'h0F0F3355);
    setReg(6, 8'h0F); setReg(2, 8'h05);
    doRead("R5 full compare", 32'h00FF00FF);

    // R6 rotate and ops, R8 mask
    setReg(5, 8'h00); setReg(1, 8'h00); setReg(7, 8'hFF);
    doRead("R3 seed latch", 32'hF0F0CC33);
    for (int r = 0; r < 8; r++) begin
      setReg(3, 8'(r));
      doWrite($sformatf("R6 rotate %0d", r), 8'h81);
    end
    for (int op = 0; op < 4; op++) begin
      setReg(3, 8'(op << 3));
      doWrite($sformatf("R6 op %0d", op), 8'h5C);
    end
    setReg(7, 8'h00);
    doWrite("R8 zero mask keeps latch", 8'hA5);

    // R7 fill, R10, R11 directed
    setReg(3, 8'h00); setReg(7, 8'hFF); setReg(1, 8'h0A); setReg(0, 8'h06);
    doWrite("R7 partial fill", 8'h3C);
    setReg(5, 8'h02); setReg(7, 8'h3C);
    doWrite("R10 colour write", 8'h09);
    setReg(5, 8'h03); setReg(7, 8'hF0); setReg(3, 8'h02);
    doWrite("R11 rotated mask", 8'h6E);

    // R12 enables idle and partial
    setReg(8, 8'h05);
    doWrite("R12 partial planes", 8'h11);
    #1 check("R12 idle enable", {28'h0, planeWrEn}, 32'h0);

    // random mix of all modes
    for (int it = 0; it < 250; it++) begin
      setReg(0, 8'($urandom)); setReg(1, 8'($urandom));
      setReg(2, 8'($urandom)); setReg(3, 8'($urandom));
      setReg(4, 8'($urandom)); setReg(5, 8'($urandom));
      setReg(6, 8'($urandom)); setReg(7, 8'($urandom));
      setReg(8, 8'($urandom));
      doRead("R4 R5 random read", $urandom);
      doWrite("R7 R8 R10 R11 random write", 8'($urandom));
    end

    finished = 1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule